// File: doc/BRIEF.md
# Stereo Two-Stage PCM Upsampler

This block raises the rate of a stereo PCM stream by a factor of 128 or 64, ready for a one-bit noise-shaping modulator. Each accepted frame carries one signed 24-bit left sample and one signed 24-bit right sample. The first stage is a fixed four-times polyphase low-pass interpolator. It removes the spectral copies that sit at multiples of the input rate. The second stage is a digital zero-order hold. It repeats each filtered value 32 times in base rate mode and 16 times in high rate mode. After the hold, the only images left are at multiples of four times the input rate.

Both channels share one multiply-accumulate unit. The unit alternates between left and right on every tap of a polyphase step. Each channel keeps its own three-sample history and its own accumulator. A frame is taken on `in_valid` while `in_ready` is high. The mode pin is sampled only at that moment. After a fixed start latency, the block then emits one contiguous burst of strobes, four hold groups long, and returns to idle.

A controller moves through four named states:
- `ST_IDLE`: ready for a frame. It goes to `ST_PRIME` when a frame is accepted.
- `ST_PRIME`: computes the first polyphase output in seven cycles. It then goes to `ST_RUN` and starts holding.
- `ST_RUN`: holds the current value and computes the next phase in the background. At each group end it loads that phase. After phase 3 is loaded it goes to `ST_DRAIN`.
- `ST_DRAIN`: holds the last phase. It goes back to `ST_IDLE` at the end of that group.

Top module: `pcm_upsampler`

## Requirements
- R1: `in_ready` is high exactly when the block is idle, and is never high while `out_strobe` is high. An `in_valid` pulse while `in_ready` is low is ignored: it changes neither the current burst nor the output of later frames.
- R2: If a frame is accepted at clock edge E0, `out_strobe` first goes high after edge E7 and is sampled high at edge E8.
- R3: With `hi_rate` = 0 at acceptance, a frame yields exactly 128 contiguous strobes, made of 4 groups of 32.
- R4: With `hi_rate` = 1 at acceptance, a frame yields exactly 64 contiguous strobes, made of 4 groups of 16.
- R5: A change of `hi_rate` while a frame is in progress has no effect on that frame's group length or strobe count.
- R6: Let x0, x1 and x2 be the newest three samples of a channel. Group p (p = 0..3) of the newest frame then carries y = (c[p]·x0 + c[p+4]·x1 + c[p+8]·x2 + 8) >> 4, with an arithmetic shift. The coefficient list is c = −1, −1, 2, 6, 11, 15, 15, 11, 6, 2, −1, −1.
- R7: A result above 8388607 is clamped to 8388607, and a result below −8388608 is clamped to −8388608.
- R8: A constant input value reproduces itself exactly on every strobe once three frames of that value have been accepted.
- R9: The left output depends only on left inputs, and the right output depends only on right inputs.
- R10: After reset, `in_ready` is 1, `out_strobe` is 0, both outputs are 0, and the sample histories hold zeros.
- R11: Within one hold group the output values do not change from strobe to strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame is offered on the sample inputs |
| in_ready | output | 1 | Block is idle and takes the offered frame |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| hi_rate | input | 1 | 1 selects the 16-fold hold, 0 the 32-fold hold; sampled at acceptance |
| out_strobe | output | 1 | High for each oversampled output value |
| out_left | output | 24 | Left oversampled value, two's complement |
| out_right | output | 24 | Right oversampled value, two's complement |

## Verification
On every cycle, the bound checker tracks the handshake exclusion and the seven-edge start latency. It also checks the burst length against the mode captured at acceptance, and the stability of the outputs inside each hold group. The numeric content needs the bench's scenarios:
- polyphase coefficients in order after an impulse;
- exact reproduction of a held constant;
- clamping at both rails;
- independence of the two channels;
- a long alternating-mode sweep compared against an arithmetic model.

Those scenarios also show that a pulse on `in_valid` during a busy burst leaves every later frame's output unchanged.

// File: rtl/ups_pkg.sv
package ups_pkg;

    localparam int PHASES    = 4;   // interpolation factor of the filter stage
    localparam int TAPS      = 3;   // taps per polyphase branch
    localparam int NCH       = 2;   // left and right
    localparam int COEF_W    = 6;   // signed coefficient width
    localparam int COEF_FRAC = 4;   // coefficients are in sixteenths

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } ups_state_t;

    // Symmetric prototype low-pass, 12 taps, every polyphase branch sums to 16.
    function automatic logic signed [COEF_W-1:0] proto_tap(input int idx);
        int m;
        m = (idx < 6) ? idx : 11 - idx;
        case (m)
            0:       proto_tap = -6'sd1;
            1:       proto_tap = -6'sd1;
            2:       proto_tap = 6'sd2;
            3:       proto_tap = 6'sd6;
            4:       proto_tap = 6'sd11;
            5:       proto_tap = 6'sd15;
            default: proto_tap = 6'sd0;
        endcase
    endfunction

    // Coefficient for branch ph applied to the sample tap frames old.
    function automatic logic signed [COEF_W-1:0] poly_coef(input logic [1:0] ph,
                                                           input logic [1:0] tap);
        return proto_tap(int'(ph) + PHASES * int'(tap));
    endfunction

endpackage

// File: rtl/ups_history.sv
module ups_history #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [DATA_W-1:0]              din,
    output logic [DEPTH-1:0][DATA_W-1:0]   taps
);

    logic [DEPTH:0][DATA_W-1:0] chain;

    assign chain[0] = din;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g+1] <= '0;
            end else if (load) begin
                chain[g+1] <= chain[g];
            end
        end
    end

    assign taps = chain[DEPTH:1];

endmodule

// File: rtl/ups_mac.sv
module ups_mac #(
    parameter int DATA_W = 24,
    parameter int COEF_W = 6,
    parameter int FRAC_W = 4,
    parameter int NCH    = 2,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ACC_W = DATA_W + COEF_W + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          clear,
    input  logic [CH_W-1:0]               chan,
    input  logic signed [COEF_W-1:0]      coef,
    input  logic [DATA_W-1:0]             sample,
    output logic [NCH-1:0][DATA_W-1:0]    res
);

    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] c_ext;
    logic signed [ACC_W-1:0] s_ext;
    logic signed [ACC_W-1:0] prod;

    assign c_ext = ACC_W'(coef);
    assign s_ext = ACC_W'($signed(sample));
    assign prod  = c_ext * s_ext;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] rnd;
        logic [DATA_W-1:0]       sat_v;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (clear) begin
                acc_q <= '0;
            end else if (en && (chan == CH_W'(g))) begin
                acc_q <= acc_q + prod;
            end
        end

        assign rnd = (acc_q + HALF) >>> FRAC_W;

        always_comb begin
            if (rnd > SAT_HI) begin
                sat_v = SAT_HI[DATA_W-1:0];
            end else if (rnd < SAT_LO) begin
                sat_v = SAT_LO[DATA_W-1:0];
            end else begin
                sat_v = rnd[DATA_W-1:0];
            end
        end

        assign res[g] = sat_v;
    end

endmodule

// File: rtl/ups_hold.sv
module ups_hold #(
    parameter int DATA_W    = 24,
    parameter int NCH       = 2,
    parameter int HOLD_BASE = 32,
    parameter int HOLD_HIGH = 16,
    localparam int CNT_W    = $clog2(HOLD_BASE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_res,
    input  logic                          stash,
    input  logic                          take_stash,
    input  logic                          run,
    input  logic                          short_mode,
    input  logic [NCH-1:0][DATA_W-1:0]    res,
    output logic [NCH-1:0][DATA_W-1:0]    out_val,
    output logic                          last
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             restart;

    assign restart = take_res | take_stash;
    assign limit   = short_mode ? CNT_W'(HOLD_HIGH - 1) : CNT_W'(HOLD_BASE - 1);
    assign last    = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DATA_W-1:0] pend_q;
        logic [DATA_W-1:0] held_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (stash) begin
                pend_q <= res[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q <= '0;
            end else if (take_res) begin
                held_q <= res[g];
            end else if (take_stash) begin
                held_q <= pend_q;
            end
        end

        assign out_val[g] = held_q;
    end

endmodule

// File: rtl/ups_ctrl.sv
module ups_ctrl
    import ups_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        hi_rate,
    input  logic        hold_last,
    output logic        in_ready,
    output logic        out_strobe,
    output logic        hist_load,
    output logic        mac_en,
    output logic        mac_clear,
    output logic        mac_chan,
    output logic [1:0]  mac_tap,
    output logic [1:0]  mac_phase,
    output logic        take_res,
    output logic        stash,
    output logic        take_stash,
    output logic        hold_run,
    output logic        short_mode
);

    localparam logic [2:0] STEP_COMMIT = 3'(2 * TAPS);
    localparam logic [2:0] STEP_DONE   = 3'(2 * TAPS + 1);
    localparam logic [1:0] PH_LAST     = 2'(PHASES - 1);

    ups_state_t state_q, state_n;
    logic [2:0] step_q, step_n;
    logic [1:0] ph_q, ph_n;
    logic       mode_q, mode_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            ph_q    <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            step_q  <= step_n;
            ph_q    <= ph_n;
            mode_q  <= mode_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        step_n  = step_q;
        ph_n    = ph_q;
        mode_n  = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_n = ST_PRIME;
                    step_n  = '0;
                    ph_n    = '0;
                    mode_n  = hi_rate;
                end
            end
            ST_PRIME: begin
                if (step_q == STEP_COMMIT) begin
                    state_n = ST_RUN;
                    step_n  = '0;
                    ph_n    = 2'd1;
                end else begin
                    step_n = step_q + 3'd1;
                end
            end
            ST_RUN: begin
                if (hold_last) begin
                    step_n = '0;
                    if (ph_q == PH_LAST) begin
                        state_n = ST_DRAIN;
                    end else begin
                        ph_n = ph_q + 2'd1;
                    end
                end else if (step_q != STEP_DONE) begin
                    step_n = step_q + 3'd1;
                end
            end
            ST_DRAIN: begin
                if (hold_last) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        logic computing;
        computing  = (state_q == ST_PRIME) || (state_q == ST_RUN);
        in_ready   = (state_q == ST_IDLE);
        hist_load  = (state_q == ST_IDLE) && in_valid;
        mac_en     = computing && (step_q < STEP_COMMIT);
        mac_clear  = computing && (step_q == STEP_COMMIT);
        mac_chan   = step_q[0];
        mac_tap    = step_q[2:1];
        mac_phase  = ph_q;
        take_res   = (state_q == ST_PRIME) && (step_q == STEP_COMMIT);
        stash      = (state_q == ST_RUN) && (step_q == STEP_COMMIT);
        take_stash = (state_q == ST_RUN) && hold_last;
        hold_run   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        out_strobe = hold_run;
        short_mode = mode_q;
    end

endmodule

// File: rtl/pcm_upsampler.sv
module pcm_upsampler
    import ups_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int HOLD_BASE = 32,
    parameter int HOLD_HIGH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              hi_rate,
    output logic              out_strobe,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    localparam int CH_W = 1;

    logic [NCH-1:0][DATA_W-1:0]            in_pair;
    logic [NCH-1:0][TAPS-1:0][DATA_W-1:0]  hist;
    logic [NCH-1:0][DATA_W-1:0]            mac_res;
    logic [NCH-1:0][DATA_W-1:0]            held;

    logic                     hist_load;
    logic                     mac_en;
    logic                     mac_clear;
    logic                     mac_chan;
    logic [1:0]               mac_tap;
    logic [1:0]               mac_phase;
    logic                     take_res;
    logic                     stash;
    logic                     take_stash;
    logic                     hold_run;
    logic                     short_mode;
    logic                     hold_last;
    logic signed [COEF_W-1:0] coef;
    logic [DATA_W-1:0]        sample;

    assign in_pair[0] = in_left;
    assign in_pair[1] = in_right;

    for (genvar g = 0; g < NCH; g++) begin : g_hist
        ups_history #(
            .DATA_W (DATA_W),
            .DEPTH  (TAPS)
        ) u_hist (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (hist_load),
            .din   (in_pair[g]),
            .taps  (hist[g])
        );
    end

    ups_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .hi_rate    (hi_rate),
        .hold_last  (hold_last),
        .in_ready   (in_ready),
        .out_strobe (out_strobe),
        .hist_load  (hist_load),
        .mac_en     (mac_en),
        .mac_clear  (mac_clear),
        .mac_chan   (mac_chan),
        .mac_tap    (mac_tap),
        .mac_phase  (mac_phase),
        .take_res   (take_res),
        .stash      (stash),
        .take_stash (take_stash),
        .hold_run   (hold_run),
        .short_mode (short_mode)
    );

    assign coef = poly_coef(mac_phase, mac_tap);

    always_comb begin
        sample = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++) begin
                if ((mac_chan == CH_W'(c)) && (mac_tap == 2'(t))) begin
                    sample = hist[c][t];
                end
            end
        end
    end

    ups_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC_W (COEF_FRAC),
        .NCH    (NCH)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mac_en),
        .clear  (mac_clear),
        .chan   (mac_chan),
        .coef   (coef),
        .sample (sample),
        .res    (mac_res)
    );

    ups_hold #(
        .DATA_W    (DATA_W),
        .NCH       (NCH),
        .HOLD_BASE (HOLD_BASE),
        .HOLD_HIGH (HOLD_HIGH)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_res   (take_res),
        .stash      (stash),
        .take_stash (take_stash),
        .run        (hold_run),
        .short_mode (short_mode),
        .res        (mac_res),
        .out_val    (held),
        .last       (hold_last)
    );

    assign out_left  = held[0];
    assign out_right = held[1];

endmodule

// File: rtl/ups_checker.sv
module ups_checker #(
    parameter int DATA_W    = 24,
    parameter int HOLD_BASE = 32,
    parameter int HOLD_HIGH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic              hi_rate,
    input  logic              out_strobe,
    input  logic [DATA_W-1:0] out_left,
    input  logic [DATA_W-1:0] out_right
);

    localparam int LEN_W = $clog2(HOLD_BASE) + 1;
    localparam int SC_W  = LEN_W + 2;

    logic [3:0]       lat_q;
    logic [LEN_W-1:0] len_q;
    logic [SC_W-1:0]  scnt_q;
    logic             took;

    assign took = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            len_q  <= LEN_W'(HOLD_BASE);
            scnt_q <= '0;
        end else if (took) begin
            lat_q  <= 4'd1;
            len_q  <= hi_rate ? LEN_W'(HOLD_HIGH) : LEN_W'(HOLD_BASE);
            scnt_q <= '0;
        end else begin
            if ((lat_q != 4'd0) && !out_strobe && (lat_q != 4'hF)) begin
                lat_q <= lat_q + 4'd1;
            end
            if (out_strobe) begin
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_strobe)); // R1

    AST_START_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_strobe) |-> (lat_q == 4'd8)); // R2

    // burst length uses the mode held since acceptance (R4, R5 as well)
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_strobe) |-> (scnt_q == (SC_W'(len_q) << 2))); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && $past(out_strobe) && ((scnt_q & SC_W'(len_q - 1'b1)) != '0))
        |-> ($stable(out_left) && $stable(out_right))); // R11

endmodule

bind pcm_upsampler ups_checker #(
    .DATA_W    (DATA_W),
    .HOLD_BASE (HOLD_BASE),
    .HOLD_HIGH (HOLD_HIGH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .hi_rate    (hi_rate),
    .out_strobe (out_strobe),
    .out_left   (out_left),
    .out_right  (out_right)
);

// File: tb/tb_pcm_upsampler.sv
module tb_pcm_upsampler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        hi_rate = 1'b0;
    logic        out_strobe;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    longint hl [3];
    longint hr [3];
    int cf [12] = '{-1, -1, 2, 6, 11, 15, 15, 11, 6, 2, -1, -1};
    bit [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pcm_upsampler dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_left    (in_left),
        .in_right   (in_right),
        .hi_rate    (hi_rate),
        .out_strobe (out_strobe),
        .out_left   (out_left),
        .out_right  (out_right)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input int p, input longint x0, input longint x1,
                                     input longint x2);
        longint s;
        s = cf[p] * x0 + cf[p+4] * x1 + cf[p+8] * x2;
        s = (s + 8) >>> 4;
        if (s > 64'sd8388607) s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return s;
    endfunction

    function automatic bit [31:0] next_rand(input bit [31:0] v);
        bit [31:0] x;
        x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One frame: offer, check latency, every strobe, burst end.
    task automatic frame(input logic signed [23:0] l, input logic signed [23:0] r,
                         input bit mode, input string tag_l, input string tag_r,
                         input string tag_len, input bit toggle, input bit poke);
        int hold;
        int lat;
        longint exp_l [4];
        longint exp_r [4];
        longint first_l;
        longint first_r;
        bit stab_ok;
        bit len_ok;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        hi_rate  = mode;
        @(negedge clk);
        in_valid = 1'b0;
        hl[2] = hl[1]; hl[1] = hl[0]; hl[0] = longint'(l);
        hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = longint'(r);
        for (int p = 0; p < 4; p++) begin
            exp_l[p] = model(p, hl[0], hl[1], hl[2]);
            exp_r[p] = model(p, hr[0], hr[1], hr[2]);
        end
        hold = mode ? 16 : 32;
        lat = 1;
        while (!out_strobe && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 8, "R2", lat, 8);
        len_ok = 1'b1;
        for (int p = 0; p < 4; p++) begin
            stab_ok = 1'b1;
            first_l = longint'($signed(out_left));
            first_r = longint'($signed(out_right));
            chk(first_l == exp_l[p], tag_l, first_l, exp_l[p]);
            chk(first_r == exp_r[p], tag_r, first_r, exp_r[p]);
            for (int j = 0; j < hold; j++) begin
                if (!out_strobe) len_ok = 1'b0;
                if (longint'($signed(out_left)) != first_l ||
                    longint'($signed(out_right)) != first_r) stab_ok = 1'b0;
                if (toggle && p == 0 && j == 3) hi_rate = ~mode;
                if (poke && p == 1 && j == 5) begin
                    chk(in_ready == 1'b0, "R1", in_ready, 0);
                    in_valid = 1'b1;
                    in_left  = 24'h5A5A5A;
                    in_right = 24'hA5A5A5;
                end
                if (poke && p == 1 && j == 6) in_valid = 1'b0;
                @(negedge clk);
            end
            chk(stab_ok, "R11", stab_ok, 1);
        end
        chk(len_ok && !out_strobe, tag_len, out_strobe, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            hl[i] = 0;
            hr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(in_ready == 1'b1, "R10", in_ready, 1);
        chk(out_strobe == 1'b0, "R10", out_strobe, 0);
        chk(out_left == '0, "R10", out_left, 0);
        chk(out_right == '0, "R10", out_right, 0);

        // R6 impulse on left with zero history (R10), constant right (R9)
        frame(24'sd16000, -24'sd4000, 1'b0, "R6", "R9", "R3", 1'b0, 1'b0);
        for (int i = 0; i < 3; i++)
            frame(24'sd0, -24'sd4000, 1'b0, "R6", "R9", "R3", 1'b0, 1'b0);

        // R8 constant in high rate mode
        for (int i = 0; i < 4; i++)
            frame(24'sd123456, -24'sd777777, 1'b1, "R8", "R8", "R4", 1'b0, 1'b0);

        // R7 clamping at both rails
        frame(24'sh7FFFFF, -24'sh800000, 1'b1, "R7", "R7", "R4", 1'b0, 1'b0);
        frame(24'sh7FFFFF, -24'sh800000, 1'b1, "R7", "R7", "R4", 1'b0, 1'b0);
        frame(-24'sh800000, 24'sh7FFFFF, 1'b1, "R7", "R7", "R4", 1'b0, 1'b0);
        frame(-24'sh800000, 24'sh7FFFFF, 1'b0, "R7", "R7", "R3", 1'b0, 1'b0);

        // R1 busy pulse ignored, R5 mode flips mid-frame
        frame(24'sd1000, 24'sd2000, 1'b0, "R1", "R1", "R1", 1'b0, 1'b1);
        frame(-24'sd3000, 24'sd500, 1'b0, "R5", "R5", "R5", 1'b1, 1'b0);
        frame(24'sd42, -24'sd42, 1'b1, "R5", "R5", "R5", 1'b1, 1'b0);

        // R6 sweep with alternating modes
        for (int i = 0; i < 24; i++) begin
            logic [23:0] a;
            logic [23:0] b;
            seed = next_rand(seed);
            a = seed[23:0];
            seed = next_rand(seed);
            b = (i % 5 == 0) ? 24'h800000 : seed[23:0];
            frame(a, b, i[0], "R6", "R6", i[0] ? "R4" : "R3", 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule